// File: doc/BRIEF.md
# Byte-Wide Configuration Frame Loader

This block takes configuration data one full byte per rising edge of a configuration clock that is driven from outside. It turns the byte stream into framed payload bytes. A three-bit mode input enables it. Only the value 3'b010 lets it load; any other value keeps it idle. Once enabled, the first rising edge only arms the loader. Data bytes then arrive on every edge after that, with no gaps.

Each frame has a fixed start byte, a fixed number of payload bytes and a fixed stop byte. The block hands each payload byte to the storage behind it on a frame-data bus. A one-cycle valid strobe and the byte's position within the frame go with it.

The stream carries no length count and no CRC. Loading ends when an end-of-stream code arrives in the slot where a start byte is expected. Errors are found only by comparing the start and stop bytes against their fixed values. A mismatch raises a sticky error flag and stops loading.

Top module: `bytecfg_loader`

## Requirements
- R1: A rising clock edge with `rst_n` low clears `fd_valid`, `done` and `err`, and returns the loader to waiting for the setup edge.
- R2: The loader is enabled only when `mode` equals 3'b010. On any edge with another mode value, no byte is captured and no output strobe is produced. The loader then drops the frame in progress and waits for a new setup edge, but keeps `done` and `err` as they are.
- R3: The first enabled edge after waiting is a setup edge. The byte on `din` at that edge is ignored. The byte on the next edge is treated as a frame header.
- R4: Each payload byte is captured on its edge and appears on `fd_data` for exactly one cycle after that edge, with `fd_valid` high. `fd_index` counts 0 to PAYLOAD_BYTES-1 within the frame.
- R5: A frame is the start code (default 8'hFE), then PAYLOAD_BYTES payload bytes (default 4), then the stop code (default 8'hFF). The next header is taken on the edge right after the stop byte.
- R6: A header byte that is neither the start code nor the end code sets `err`. `err` stays high until reset, and no further payload is output.
- R7: A byte in the stop position that differs from the stop code sets `err`, with the same lasting effect as R6.
- R8: The end code (default 8'hA5) in the header position sets `done`. `done` stays high until reset, and all later bytes produce no output.
- R9: Payload bytes are never decoded, so payload values equal to the start, stop or end codes are passed through as data. No byte in the stream is read as a length.
- R10: After a reset, a stream that is loaded after an error works again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Externally driven configuration clock; all capture on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Mode select; 3'b010 enables byte-wide loading |
| din | input | 8 | Configuration data byte |
| fd_data | output | 8 | Captured payload byte |
| fd_valid | output | 1 | One-cycle strobe marking a payload byte on `fd_data` |
| fd_index | output | clog2(PAYLOAD_BYTES) | Position of the payload byte within its frame |
| done | output | 1 | Sticky flag: end-of-stream code received |
| err | output | 1 | Sticky flag: start or stop byte mismatch |

## Verification
A loader whose frame state drifted by even one byte would show it within one frame. Valid strobes would carry a shifted index, or a header or stop byte would be passed out as data, and the scoreboard compares both on the very next cycle. If the setup edge were miscounted, or the mode gate failed to drop progress, a garbage byte would land in the header slot. That raises `err` one cycle later, where the bench checks the flags. The bench also places the frame constants inside payloads, so a loader that decodes payload bytes would end early or flag a false error.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

  typedef enum logic [2:0] {
    LD_WAIT,
    LD_HEAD,
    LD_BODY,
    LD_TAIL,
    LD_DONE,
    LD_FAIL
  } ld_state_t;

  localparam logic [2:0] LOAD_MODE = 3'b010;

  function automatic logic mode_selects_load(input logic [2:0] m);
    return m == LOAD_MODE;
  endfunction

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic logic is_terminal(input ld_state_t s);
    return (s == LD_DONE) || (s == LD_FAIL);
  endfunction

endpackage

// File: rtl/bcl_mode_gate.sv
module bcl_mode_gate
  import bcl_pkg::*;
(
  input  logic [2:0] mode,
  output logic       act
);
  assign act = mode_selects_load(mode);
endmodule

// File: rtl/bcl_idx_ctr.sv
module bcl_idx_ctr #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [IW-1:0] idx,
  output logic          last
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  assign last = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx <= '0;
    else if (inc)      idx <= last ? '0 : idx + 1'b1;
  end

  p_index_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

endmodule

// File: rtl/bcl_framer.sv
module bcl_framer
  import bcl_pkg::*;
#(
  parameter int unsigned N          = 4,
  parameter int unsigned IW         = 2,
  parameter logic [7:0]  START_CODE = 8'hFE,
  parameter logic [7:0]  STOP_CODE  = 8'hFF,
  parameter logic [7:0]  END_CODE   = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic [7:0]    din,
  input  logic [IW-1:0] idx,
  input  logic          idx_last,
  output logic          idx_clr,
  output logic          idx_inc,
  output logic [7:0]    fd_data,
  output logic          fd_valid,
  output logic [IW-1:0] fd_index,
  output logic          done,
  output logic          err
);
  ld_state_t st, nxt;

  // named internal events
  logic hdr_start, hdr_eos, hdr_bad, tail_bad, body_cap;

  assign hdr_start = act && (st == LD_HEAD) && (din == START_CODE);
  assign hdr_eos   = act && (st == LD_HEAD) && (din == END_CODE);
  assign hdr_bad   = act && (st == LD_HEAD) && !hdr_start && !hdr_eos;
  assign tail_bad  = act && (st == LD_TAIL) && (din != STOP_CODE);
  assign body_cap  = act && (st == LD_BODY);

  assign idx_clr = !act || (st != LD_BODY);
  assign idx_inc = body_cap;

  always_comb begin
    nxt = st;
    if (!act) begin
      if (!is_terminal(st)) nxt = LD_WAIT;
    end else begin
      case (st)
        LD_WAIT: nxt = LD_HEAD;
        LD_HEAD: nxt = hdr_start ? LD_BODY : (hdr_eos ? LD_DONE : LD_FAIL);
        LD_BODY: nxt = idx_last ? LD_TAIL : LD_BODY;
        LD_TAIL: nxt = tail_bad ? LD_FAIL : LD_HEAD;
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LD_WAIT;
      fd_valid <= 1'b0;
      fd_data  <= '0;
      fd_index <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      st       <= nxt;
      fd_valid <= body_cap;
      if (body_cap) begin
        fd_data  <= din;
        fd_index <= idx;
      end
      if (hdr_eos)             done <= 1'b1;
      if (hdr_bad || tail_bad) err  <= 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!fd_valid && !done && !err && st == LD_WAIT));
  p_valid_needs_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fd_valid |-> $past(act));
  p_setup_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LD_WAIT) |=> !fd_valid);
  p_body_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LD_BODY) |-> $past(st == LD_HEAD || st == LD_BODY));
  p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(st == LD_HEAD || st == LD_TAIL));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !fd_valid));
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !fd_valid));
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

endmodule

// File: rtl/bytecfg_loader.sv
module bytecfg_loader
  import bcl_pkg::*;
#(
  parameter int unsigned PAYLOAD_BYTES = 4,
  parameter logic [7:0]  START_CODE    = 8'hFE,
  parameter logic [7:0]  STOP_CODE     = 8'hFF,
  parameter logic [7:0]  END_CODE      = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic [7:0] din,
  output logic [7:0] fd_data,
  output logic       fd_valid,
  output logic [idx_bits(PAYLOAD_BYTES)-1:0] fd_index,
  output logic       done,
  output logic       err
);
  localparam int unsigned IW = idx_bits(PAYLOAD_BYTES);

  logic          act;
  logic          idx_clr, idx_inc, idx_last;
  logic [IW-1:0] idx;

  bcl_mode_gate u_gate (
    .mode (mode),
    .act  (act)
  );

  bcl_idx_ctr #(.N(PAYLOAD_BYTES), .IW(IW)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idx_clr),
    .inc   (idx_inc),
    .idx   (idx),
    .last  (idx_last)
  );

  bcl_framer #(
    .N(PAYLOAD_BYTES), .IW(IW),
    .START_CODE(START_CODE), .STOP_CODE(STOP_CODE), .END_CODE(END_CODE)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .din      (din),
    .idx      (idx),
    .idx_last (idx_last),
    .idx_clr  (idx_clr),
    .idx_inc  (idx_inc),
    .fd_data  (fd_data),
    .fd_valid (fd_valid),
    .fd_index (fd_index),
    .done     (done),
    .err      (err)
  );

endmodule

// File: tb/tb_bytecfg_loader.sv
module tb_bytecfg_loader;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam logic [2:0] ON = 3'b010;
  localparam logic [7:0] SB = 8'hFE, PB = 8'hFF, EB = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [7:0] din = 8'h00;
  logic [7:0] fd_data;
  logic fd_valid;
  logic [IW-1:0] fd_index;
  logic done, err;

  int tests = 0;
  int fails = 0;
  logic [IW+7:0] q[$];

  always #10 clk = ~clk;

  bytecfg_loader #(.PAYLOAD_BYTES(N)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .din(din),
    .fd_data(fd_data), .fd_valid(fd_valid), .fd_index(fd_index),
    .done(done), .err(err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected payload items (R4 order, data and index)
  always @(negedge clk) begin
    if (rst_n && fd_valid) begin
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R2 R6 R8 unexpected strobe: actual %0h expected none", fd_data);
      end else begin
        logic [IW+7:0] e;
        e = q.pop_front();
        if ({fd_index, fd_data} !== e) begin
          fails++;
          $display("FAIL R4 payload: actual %0h expected %0h", {fd_index, fd_data}, e);
        end
      end
    end
  end

  task automatic drv(input logic [2:0] m, input logic [7:0] b);
    @(negedge clk);
    mode = m;
    din  = b;
  endtask

  task automatic send_frame(input logic [8*N-1:0] w, input logic [7:0] stop, input bit expect_out);
    drv(ON, SB);
    for (int i = 0; i < N; i++) begin
      logic [7:0] b;
      b = w[8*i +: 8];
      if (expect_out) q.push_back({IW'(i), b});
      drv(ON, b);
    end
    drv(ON, stop);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mode = 3'b000; din = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1", "valid in reset", fd_valid, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "err in reset", err, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R2: other modes hold the loader idle and do not arm it
    drv(3'b000, SB); drv(3'b110, SB); drv(3'b011, 8'h11); drv(3'b111, EB);
    drv(ON, 8'h55);   // R3 setup edge; garbage ignored
    drv(ON, EB);      // header slot: end code
    drv(ON, 8'h00);
    chk("R2", "done after idle modes then end", done, 1);
    chk("R3", "err after garbage setup byte", err, 0);

    // R4 R5 R9: multi-frame stream
    do_reset();
    drv(ON, 8'h13);   // R3 setup edge with non-header value
    send_frame(32'h44332211, PB, 1);
    send_frame({EB, PB, SB, 8'h00}, PB, 1); // R9 constants as payload
    send_frame(32'hC0DE5A7E, PB, 1);
    drv(ON, EB);
    send_frame(32'h99887766, PB, 0);        // R8 ignored after end
    chk("R8", "done after end code", done, 1);
    chk("R5", "no error on good stream", err, 0);
    chk("R4", "all payload seen", q.size(), 0);

    // R2: mode drop mid-frame drops progress
    do_reset();
    drv(ON, 8'h00);
    drv(ON, SB);
    q.push_back({IW'(0), 8'hA1}); drv(ON, 8'hA1);
    q.push_back({IW'(1), 8'hB2}); drv(ON, 8'hB2);
    drv(3'b000, 8'hC3);
    drv(ON, 8'h77);   // new setup edge
    send_frame(32'h0D0C0B0A, PB, 1);
    drv(ON, EB);
    drv(ON, 8'h00);
    chk("R2", "done after resumed stream", done, 1);
    chk("R2", "no err after mode drop", err, 0);
    chk("R2", "payload after mode drop", q.size(), 0);

    // R7: corrupted stop byte
    do_reset();
    drv(ON, 8'h00);
    send_frame(32'h04030201, 8'h7F, 1);
    drv(ON, 8'h00);
    chk("R7", "err after bad stop", err, 1);
    chk("R7", "done stays low", done, 0);
    send_frame(32'h08070605, PB, 0);
    drv(ON, EB);
    drv(ON, 8'h00);
    chk("R7", "err sticky", err, 1);
    chk("R7", "end ignored after err", done, 0);

    // R6: bad header
    do_reset();
    drv(ON, 8'h00);
    drv(ON, 8'h12);
    drv(ON, SB);
    chk("R6", "err after bad header", err, 1);
    send_frame(32'h11111111, PB, 0);
    chk("R6", "err still set", err, 1);

    // R10: recovery after reset
    do_reset();
    drv(ON, 8'h00);
    send_frame(32'h5A5A5A5A, PB, 1);
    drv(ON, EB);
    drv(ON, 8'h00);
    chk("R10", "done after recovery", done, 1);
    chk("R10", "err clear after recovery", err, 0);
    chk("R10", "payload after recovery", q.size(), 0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule